// File: doc/BRIEF.md
# Scatter-Gather Memory-to-Stream Descriptor Walker

This block is the descriptor engine of one transmit DMA channel. It walks a linked list of descriptors held in memory. For each one it fetches the fields it needs over a simple word-wide request/response memory port. It sends the descriptor's buffer out as 32-bit beats on a valid/ready data stream, with a byte keep mask. It then writes the status word back with its complete bit set, and moves on along the next pointer. It stops after the descriptor whose address equals the tail pointer.

The register and interrupt logic drives the block through pulses and levels: a run level, a start pulse, a tail-pointer write and a current-pointer write. It reads back the halted and idle flags, the current pointer and a one-cycle pulse for each finished end-of-frame descriptor. A descriptor that is flagged as the start of a frame first sends its five application words on a separate sideband stream.

A descriptor is 13 little-endian 32-bit words at byte offsets from its base. The next pointer is at 0x00, with its upper half at 0x04. The buffer address is at 0x08, with its upper half at 0x0C. A reserved pair sits at 0x10 and 0x14. The control word is at 0x18, the status word at 0x1C, and the application words at 0x20 through 0x30. Only the low ADDR_W bits of a pointer are used. Each fetch reads four words in a fixed order: status, then control, then next pointer, then buffer address.

Top module: `sgw_walker`

## Requirements
- R1: After reset, halted_o is 1, idle_o is 0, and no memory request, data beat, application beat or completion pulse is presented.
- R2: A fetch begins only while run_i is 1, idle is 0 and halted is 0. A start_i pulse clears both halted and idle. While these conditions do not hold, no memory request is issued.
- R3: The status word (offset 0x1C) is read first. If its bit 31 is already set, the engine sets halted and returns to waiting. In that case it reads nothing more, sends no beat, writes nothing back and leaves the current pointer unchanged.
- R4: When control bit 27 (start of frame) is set, the five application words at offsets 0x20..0x30 go out on the application stream, in ascending order, before any data beat of that descriptor. app_tlast_o is 1 on the fifth word only.
- R5: Control bits 22:0 give the length L in bytes. The engine sends ceil(L/4) data beats. Each beat carries the memory word read from the buffer address, which has its low two bits forced to zero, and the address rises by 4 per beat. tkeep is 4'b1111 on every beat except the last beat when L mod 4 is nonzero; that beat has keep bits [L mod 4 - 1 : 0] set.
- R6: dat_tlast_o is 1 only on the final beat of a descriptor whose control bit 26 (end of frame) is set. A descriptor with L = 0 sends no data beat.
- R7: While a valid beat waits for ready on either stream, its valid, data, keep and last stay unchanged.
- R8: After the transfer, the word 0x8000_0000 | L is written to the status offset 0x1C of the descriptor.
- R9: eof_done_o pulses for exactly one cycle for each processed descriptor whose control bit 26 is set, after its status write has been accepted.
- R10: After a descriptor whose address equals the tail pointer, idle_o becomes 1, the walk stops and the current pointer keeps that address. Otherwise the current pointer takes the low bits of the next pointer at offset 0x00.
- R11: A tail-pointer write clears idle and lets the walk resume. A current-pointer write takes effect while the engine is waiting between descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Channel enable level |
| start_i | input | 1 | Pulse: clear halted and idle |
| tail_wr_i | input | 1 | Pulse: load tail pointer, clear idle |
| tail_ptr_i | input | ADDR_W | New tail pointer |
| cur_wr_i | input | 1 | Pulse: load current pointer while waiting |
| cur_ptr_i | input | ADDR_W | New current pointer |
| halted_o | output | 1 | Channel halted flag |
| idle_o | output | 1 | Tail reached flag |
| eof_done_o | output | 1 | One-cycle end-of-frame completion pulse |
| cur_ptr_o | output | ADDR_W | Current descriptor pointer |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr_o | output | ADDR_W | Byte address, word aligned |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| dat_tvalid_o | output | 1 | Data stream valid |
| dat_tready_i | input | 1 | Data stream ready |
| dat_tdata_o | output | 32 | Data stream word |
| dat_tkeep_o | output | 4 | Data byte keep mask |
| dat_tlast_o | output | 1 | End of frame on data stream |
| app_tvalid_o | output | 1 | Application stream valid |
| app_tready_i | input | 1 | Application stream ready |
| app_tdata_o | output | 32 | Application word |
| app_tlast_o | output | 1 | Fifth application word |

## Verification
Some properties are checked on every cycle. Both streams hold still under backpressure. Completion pulses last one cycle. Every status write has bit 31 set. A halted or idle channel issues no request, and tlast never appears on a descriptor without the end-of-frame bit. Other behaviour can only be shown by the bench's scenarios. These are the byte content, keep masks and ordering of the beats, the application-before-data order, the written-back status values, and the pointer movement up to the tail. They also include the gating by run and halted, and the single status read before a halt on an already-complete descriptor. The bench shows them by walking a chain whose lengths sweep 0 through 10 and whose frames span one to three descriptors, with random stalls on both the memory and the streams.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int WORD_BYTES   = 4;
    localparam int OFS_NEXT     = 0;   // word index of next pointer
    localparam int OFS_BUFA     = 2;   // word index of buffer address
    localparam int OFS_CTRL     = 6;   // word index of control word
    localparam int OFS_STAT     = 7;   // word index of status word
    localparam int OFS_APP      = 8;   // word index of first application word
    localparam int CTRL_EOF_BIT = 26;
    localparam int CTRL_SOF_BIT = 27;
    localparam int STAT_DONE_BIT = 31;

    typedef enum logic [3:0] {
        S_WAIT, S_FREQ, S_FRSP, S_AREQ, S_ARSP, S_AOUT,
        S_DREQ, S_DRSP, S_DOUT, S_WB, S_ADV
    } state_e;

    // Fetch order: status first so a completed descriptor halts early.
    function automatic logic [3:0] fetch_word(input logic [1:0] idx);
        case (idx)
            2'd0:    fetch_word = 4'(OFS_STAT);
            2'd1:    fetch_word = 4'(OFS_CTRL);
            2'd2:    fetch_word = 4'(OFS_NEXT);
            default: fetch_word = 4'(OFS_BUFA);
        endcase
    endfunction
endpackage

// File: rtl/sgw_desc_store.sv
module sgw_desc_store
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic [1:0]        cap_sel_i,
    input  logic [31:0]       cap_data_i,
    output logic [ADDR_W-1:0] nxt_o,
    output logic [ADDR_W-1:0] bufa_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              sof_o,
    output logic              eof_o
);
    typedef struct packed {
        logic [31:0]       ctrl;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] bufa;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cap_en_i) begin
            case (cap_sel_i)
                2'd1:    s_d.ctrl = cap_data_i;
                2'd2:    s_d.nxt  = cap_data_i[ADDR_W-1:0];
                2'd3:    s_d.bufa = cap_data_i[ADDR_W-1:0];
                default: s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign nxt_o  = s_q.nxt;
    assign bufa_o = s_q.bufa;
    assign len_o  = s_q.ctrl[LEN_W-1:0];
    assign sof_o  = s_q.ctrl[CTRL_SOF_BIT];
    assign eof_o  = s_q.ctrl[CTRL_EOF_BIT];
endmodule

// File: rtl/sgw_keep_gen.sv
module sgw_keep_gen
    import sgw_pkg::*;
#(
    parameter int LEN_W = 23
) (
    input  logic [LEN_W-1:0]      rem_i,
    output logic [WORD_BYTES-1:0] keep_o,
    output logic                  is_last_o
);
    for (genvar j = 0; j < WORD_BYTES; j++) begin : g_lane
        assign keep_o[j] = (rem_i > LEN_W'(j));
    end
    assign is_last_o = (rem_i <= LEN_W'(WORD_BYTES));
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 23,
    parameter int APP_N  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              start_i,
    input  logic              tail_wr_i,
    input  logic [ADDR_W-1:0] tail_ptr_i,
    input  logic              cur_wr_i,
    input  logic [ADDR_W-1:0] cur_ptr_i,
    output logic              halted_o,
    output logic              idle_o,
    output logic              eof_done_o,
    output logic [ADDR_W-1:0] cur_ptr_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic              mem_req_we_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    output logic [31:0]       mem_req_wdata_o,
    input  logic              mem_rsp_valid_i,
    input  logic [31:0]       mem_rsp_data_i,
    output logic              dat_tvalid_o,
    input  logic              dat_tready_i,
    output logic [31:0]       dat_tdata_o,
    output logic [3:0]        dat_tkeep_o,
    output logic              dat_tlast_o,
    output logic              app_tvalid_o,
    input  logic              app_tready_i,
    output logic [31:0]       app_tdata_o,
    output logic              app_tlast_o
);
    localparam int AIDX_W = (APP_N > 1) ? $clog2(APP_N) : 1;
    localparam logic [AIDX_W-1:0] AIDX_LAST = AIDX_W'(APP_N - 1);

    typedef struct packed {
        state_e                st;
        logic [1:0]            fidx;
        logic [AIDX_W-1:0]     aidx;
        logic [LEN_W-1:0]      rem;
        logic [ADDR_W-1:0]     daddr;
        logic [ADDR_W-1:0]     cur;
        logic [ADDR_W-1:0]     tail;
        logic                  halted;
        logic                  idle;
        logic                  eof_pls;
        logic                  dvalid;
        logic [31:0]           ddata;
        logic [WORD_BYTES-1:0] dkeep;
        logic                  dlast;
        logic                  avalid;
        logic [31:0]           adata;
        logic                  alast;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0]     d_nxt, d_bufa;
    logic [LEN_W-1:0]      d_len;
    logic                  d_sof, d_eof;
    logic [WORD_BYTES-1:0] k_keep;
    logic                  k_last;
    logic                  cap_en;

    assign cap_en = (r_q.st == S_FRSP) && mem_rsp_valid_i && (r_q.fidx != 2'd0);

    sgw_desc_store #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en_i   (cap_en),
        .cap_sel_i  (r_q.fidx),
        .cap_data_i (mem_rsp_data_i),
        .nxt_o      (d_nxt),
        .bufa_o     (d_bufa),
        .len_o      (d_len),
        .sof_o      (d_sof),
        .eof_o      (d_eof)
    );

    sgw_keep_gen #(.LEN_W(LEN_W)) u_keep (
        .rem_i     (r_q.rem),
        .keep_o    (k_keep),
        .is_last_o (k_last)
    );

    always_comb begin
        r_d         = r_q;
        r_d.eof_pls = 1'b0;
        mem_req_valid_o = 1'b0;
        mem_req_we_o    = 1'b0;
        mem_req_addr_o  = '0;
        mem_req_wdata_o = '0;

        case (r_q.st)
            S_WAIT: begin
                if (cur_wr_i) r_d.cur = cur_ptr_i;
                if (run_i && !r_q.idle && !r_q.halted) begin
                    r_d.st   = S_FREQ;
                    r_d.fidx = 2'd0;
                end
            end
            S_FREQ: begin
                mem_req_valid_o = 1'b1;
                mem_req_addr_o  = r_q.cur + ADDR_W'({fetch_word(r_q.fidx), 2'b00});
                if (mem_req_ready_i) r_d.st = S_FRSP;
            end
            S_FRSP: begin
                if (mem_rsp_valid_i) begin
                    if (r_q.fidx == 2'd0) begin
                        if (mem_rsp_data_i[STAT_DONE_BIT]) begin
                            r_d.halted = 1'b1;
                            r_d.st     = S_WAIT;
                        end else begin
                            r_d.fidx = 2'd1;
                            r_d.st   = S_FREQ;
                        end
                    end else if (r_q.fidx == 2'd3) begin
                        r_d.daddr = {mem_rsp_data_i[ADDR_W-1:2], 2'b00};
                        r_d.rem   = d_len;
                        r_d.aidx  = '0;
                        if (d_sof)               r_d.st = S_AREQ;
                        else if (d_len != '0)    r_d.st = S_DREQ;
                        else                     r_d.st = S_WB;
                    end else begin
                        r_d.fidx = r_q.fidx + 2'd1;
                        r_d.st   = S_FREQ;
                    end
                end
            end
            S_AREQ: begin
                mem_req_valid_o = 1'b1;
                mem_req_addr_o  = r_q.cur + ADDR_W'((OFS_APP + int'(r_q.aidx)) * WORD_BYTES);
                if (mem_req_ready_i) r_d.st = S_ARSP;
            end
            S_ARSP: begin
                if (mem_rsp_valid_i) begin
                    r_d.avalid = 1'b1;
                    r_d.adata  = mem_rsp_data_i;
                    r_d.alast  = (r_q.aidx == AIDX_LAST);
                    r_d.st     = S_AOUT;
                end
            end
            S_AOUT: begin
                if (app_tready_i) begin
                    r_d.avalid = 1'b0;
                    r_d.alast  = 1'b0;
                    if (r_q.aidx == AIDX_LAST) begin
                        r_d.st = (r_q.rem != '0) ? S_DREQ : S_WB;
                    end else begin
                        r_d.aidx = r_q.aidx + AIDX_W'(1);
                        r_d.st   = S_AREQ;
                    end
                end
            end
            S_DREQ: begin
                mem_req_valid_o = 1'b1;
                mem_req_addr_o  = r_q.daddr;
                if (mem_req_ready_i) r_d.st = S_DRSP;
            end
            S_DRSP: begin
                if (mem_rsp_valid_i) begin
                    r_d.dvalid = 1'b1;
                    r_d.ddata  = mem_rsp_data_i;
                    r_d.dkeep  = k_keep;
                    r_d.dlast  = d_eof && k_last;
                    r_d.st     = S_DOUT;
                end
            end
            S_DOUT: begin
                if (dat_tready_i) begin
                    r_d.dvalid = 1'b0;
                    r_d.dlast  = 1'b0;
                    if (k_last) begin
                        r_d.rem = '0;
                        r_d.st  = S_WB;
                    end else begin
                        r_d.rem   = r_q.rem - LEN_W'(WORD_BYTES);
                        r_d.daddr = r_q.daddr + ADDR_W'(WORD_BYTES);
                        r_d.st    = S_DREQ;
                    end
                end
            end
            S_WB: begin
                mem_req_valid_o = 1'b1;
                mem_req_we_o    = 1'b1;
                mem_req_addr_o  = r_q.cur + ADDR_W'(OFS_STAT * WORD_BYTES);
                mem_req_wdata_o = 32'h8000_0000 | 32'(d_len);
                if (mem_req_ready_i) begin
                    r_d.eof_pls = d_eof;
                    r_d.st      = S_ADV;
                end
            end
            S_ADV: begin
                if (r_q.cur == r_q.tail) r_d.idle = 1'b1;
                else                     r_d.cur  = d_nxt;
                r_d.st = S_WAIT;
            end
            default: r_d.st = S_WAIT;
        endcase

        if (start_i) begin
            r_d.halted = 1'b0;
            r_d.idle   = 1'b0;
        end
        if (tail_wr_i) begin
            r_d.tail = tail_ptr_i;
            r_d.idle = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= S_WAIT;
            r_q.halted <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign halted_o     = r_q.halted;
    assign idle_o       = r_q.idle;
    assign eof_done_o   = r_q.eof_pls;
    assign cur_ptr_o    = r_q.cur;
    assign dat_tvalid_o = r_q.dvalid;
    assign dat_tdata_o  = r_q.ddata;
    assign dat_tkeep_o  = r_q.dkeep;
    assign dat_tlast_o  = r_q.dlast;
    assign app_tvalid_o = r_q.avalid;
    assign app_tdata_o  = r_q.adata;
    assign app_tlast_o  = r_q.alast;

    // R7: data beat held under backpressure
    p_dat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_tvalid_o && !dat_tready_i) |=>
        (dat_tvalid_o && $stable(dat_tdata_o) && $stable(dat_tkeep_o) && $stable(dat_tlast_o)))
        else $error("p_dat_hold_r7");

    // R7: application beat held under backpressure
    p_app_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (app_tvalid_o && !app_tready_i) |=>
        (app_tvalid_o && $stable(app_tdata_o) && $stable(app_tlast_o)))
        else $error("p_app_hold_r7");

    // R9: completion pulse lasts a single cycle
    p_eof_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eof_done_o |=> !eof_done_o)
        else $error("p_eof_pulse_r9");

    // R3: halted channel is silent
    p_halt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> (!mem_req_valid_o && !dat_tvalid_o && !app_tvalid_o))
        else $error("p_halt_quiet_r3");

    // R10: idle channel issues no request
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !mem_req_valid_o)
        else $error("p_idle_quiet_r10");

    // R6: tlast only for an end-of-frame descriptor
    p_tlast_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_tvalid_o && dat_tlast_o) |-> d_eof)
        else $error("p_tlast_eof_r6");

    // R8: every write-back marks the descriptor complete
    p_wb_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && mem_req_we_o) |-> mem_req_wdata_o[STAT_DONE_BIT])
        else $error("p_wb_done_r8");
endmodule

// File: tb/tb_sgw_walker.sv
module tb_sgw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int MEMW       = 512;
    localparam int WD_LIMIT   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          run_i = 1'b0, start_i = 1'b0, tail_wr_i = 1'b0, cur_wr_i = 1'b0;
    logic [AW-1:0] tail_ptr_i = '0, cur_ptr_i = '0;
    logic          halted_o, idle_o, eof_done_o;
    logic [AW-1:0] cur_ptr_o;
    logic          mem_req_valid_o, mem_req_ready_i, mem_req_we_o;
    logic [AW-1:0] mem_req_addr_o;
    logic [31:0]   mem_req_wdata_o;
    logic          mem_rsp_valid_i;
    logic [31:0]   mem_rsp_data_i;
    logic          dat_tvalid_o, dat_tready_i, dat_tlast_o;
    logic [31:0]   dat_tdata_o;
    logic [3:0]    dat_tkeep_o;
    logic          app_tvalid_o, app_tready_i, app_tlast_o;
    logic [31:0]   app_tdata_o;

    sgw_walker #(.ADDR_W(AW)) dut (.*);

    // ---------------- stimulus helpers (arithmetic expected values)
    function automatic int dbase(int i);   return 32'h040 + i * 64; endfunction
    function automatic int bbase(int i);   return 32'h400 + i * 64; endfunction
    function automatic int dlen(int i);    return (i <= 10) ? i : 7; endfunction
    function automatic bit dsof(int i);    return (i == 11) || (i % 3 == 0); endfunction
    function automatic bit deof(int i);    return (i == 11) || (i == 10) || (i % 3 == 2); endfunction
    function automatic logic [31:0] pat(int w);  return 32'h9E37_0000 ^ (32'(w) * 32'h0001_0103); endfunction
    function automatic logic [31:0] appw(int i, int k); return 32'hA000_0000 | 32'(i << 8) | 32'(k); endfunction

    function automatic logic [31:0] init_word(int w);
        int b, i, k;
        b = w * 4;
        if (b >= 32'h040 && b < 32'h040 + 12 * 64) begin
            i = (b - 32'h040) / 64;
            k = ((b - 32'h040) % 64) / 4;
            case (k)
                0:  return 32'(dbase(i + 1));
                1:  return 32'hDEAD_0000 | 32'(i);
                2:  return 32'(bbase(i));
                3:  return 32'hBEEF_0000;
                6:  return 32'(dlen(i)) | (32'(dsof(i)) << 27) | (32'(deof(i)) << 26);
                7:  return 32'h0;
                8, 9, 10, 11, 12: return appw(i, k - 8);
                default: return 32'h0;
            endcase
        end else if (b >= 32'h400 && b < 32'h700) begin
            return pat(w);
        end
        return 32'h0;
    endfunction

    // ---------------- memory model and ready patterns
    logic [31:0] mem [0:MEMW-1];
    logic [7:0]  lf;
    always @(posedge clk) begin
        if (!rst_n) lf <= 8'h5B;
        else        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    assign dat_tready_i    = lf[0] | lf[3];
    assign app_tready_i    = lf[1] | lf[6];
    assign mem_req_ready_i = lf[2] | lf[5];

    always @(posedge clk) begin
        mem_rsp_valid_i <= 1'b0;
        if (!rst_n) begin
            for (int w = 0; w < MEMW; w++) mem[w] <= init_word(w);
            mem_rsp_data_i <= '0;
        end else if (mem_req_valid_o && mem_req_ready_i) begin
            if (mem_req_we_o) mem[mem_req_addr_o[10:2]] <= mem_req_wdata_o;
            else begin
                mem_rsp_valid_i <= 1'b1;
                mem_rsp_data_i  <= mem[mem_req_addr_o[10:2]];
            end
        end
    end

    // ---------------- monitor (samples at the falling edge)
    logic [37:0] act [0:127];
    logic [37:0] expd [0:127];
    int nact = 0, nreq = 0, nwr = 0, neof = 0, eof_wide = 0, hold_err = 0;
    bit prev_eof = 0, prev_stall = 0;
    logic [36:0] prev_beat;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid_o && mem_req_ready_i) begin
                nreq++;
                if (mem_req_we_o) nwr++;
            end
            if (dat_tvalid_o && dat_tready_i) begin
                act[nact] = {1'b1, dat_tlast_o, dat_tkeep_o, dat_tdata_o};
                nact++;
            end
            if (app_tvalid_o && app_tready_i) begin
                act[nact] = {1'b0, app_tlast_o, 4'h0, app_tdata_o};
                nact++;
            end
            if (eof_done_o) begin
                neof++;
                if (prev_eof) eof_wide++;
            end
            prev_eof = eof_done_o;
            if (prev_stall && (!dat_tvalid_o ||
                prev_beat != {dat_tlast_o, dat_tkeep_o, dat_tdata_o})) hold_err++;
            prev_stall = dat_tvalid_o && !dat_tready_i;
            prev_beat  = {dat_tlast_o, dat_tkeep_o, dat_tdata_o};
        end
    end

    // ---------------- checking
    int checks = 0, failures = 0, nexp = 0;
    bit wd_hit = 0;

    task automatic check(input bit ok, input string tag, input longint a, input longint e);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    task automatic exp_desc(input int i);
        int l, nb;
        l  = dlen(i);
        nb = (l + 3) / 4;
        if (dsof(i))
            for (int k = 0; k < 5; k++) begin
                expd[nexp] = {1'b0, (k == 4), 4'h0, appw(i, k)};
                nexp++;
            end
        for (int b = 0; b < nb; b++) begin
            logic [3:0] kp;
            kp = (b == nb - 1 && (l % 4) != 0) ? 4'((1 << (l % 4)) - 1) : 4'hF;
            expd[nexp] = {1'b1, deof(i) && (b == nb - 1), kp, pat(bbase(i) / 4 + b)};
            nexp++;
        end
    endtask

    task automatic cmp_log(input int from);
        check(nact == nexp, "R5 beat count", nact, nexp);
        for (int n = from; n < nexp && n < nact; n++) begin
            if (expd[n][37]) begin
                check(act[n][37:32] == expd[n][37:32] || act[n][37] != 1'b1 ? act[n][37:32] == expd[n][37:32] : 1'b0,
                      "R6 beat type/last", act[n][37:32], expd[n][37:32]);
                check(act[n][35:0] == expd[n][35:0], "R5 data/keep", act[n][35:0], expd[n][35:0]);
            end else begin
                check(act[n] == expd[n], "R4 app word order/last", act[n], expd[n]);
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask
    task automatic write_tail(input int a);
        @(negedge clk) begin tail_wr_i = 1'b1; tail_ptr_i = AW'(a); end
        @(negedge clk) tail_wr_i = 1'b0;
    endtask
    task automatic write_cur(input int a);
        @(negedge clk) begin cur_wr_i = 1'b1; cur_ptr_i = AW'(a); end
        @(negedge clk) cur_wr_i = 1'b0;
    endtask
    task automatic wait_stop();
        do @(negedge clk); while (!(idle_o || halted_o));
    endtask

    task automatic run_tests();
        int wr0, act0, req0, base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(halted_o == 1'b1, "R1 halted after reset", halted_o, 1);
        check(idle_o == 1'b0, "R1 idle after reset", idle_o, 0);
        check(!mem_req_valid_o && !dat_tvalid_o && !app_tvalid_o && !eof_done_o,
              "R1 quiet after reset", {mem_req_valid_o, dat_tvalid_o, app_tvalid_o, eof_done_o}, 0);

        // R2 / R11: halted blocks the walk even with run high
        write_cur(dbase(0));
        check(cur_ptr_o == AW'(dbase(0)), "R11 current pointer write", cur_ptr_o, dbase(0));
        write_tail(dbase(10));
        run_i = 1'b1;
        repeat (40) @(negedge clk);
        check(nreq == 0, "R2 no fetch while halted", nreq, 0);
        run_i = 1'b0;
        pulse_start();
        check(halted_o == 1'b0, "R2 start clears halted", halted_o, 0);
        repeat (40) @(negedge clk);
        check(nreq == 0, "R2 no fetch while run low", nreq, 0);

        // Chain sweep: lengths 0..10, frames of one to three descriptors
        for (int i = 0; i <= 10; i++) exp_desc(i);
        run_i = 1'b1;
        wait_stop();
        check(idle_o == 1'b1 && halted_o == 1'b0, "R10 idle at tail", {idle_o, halted_o}, 2'b10);
        check(cur_ptr_o == AW'(dbase(10)), "R10 pointer stays at tail", cur_ptr_o, dbase(10));
        cmp_log(0);
        for (int i = 0; i <= 10; i++)
            check(mem[dbase(i) / 4 + 7] == (32'h8000_0000 | 32'(dlen(i))), "R8 status write-back",
                  mem[dbase(i) / 4 + 7], 32'h8000_0000 | 32'(dlen(i)));
        check(neof == 4, "R9 completion pulse count", neof, 4);
        check(eof_wide == 0, "R9 pulse width", eof_wide, 0);
        check(hold_err == 0, "R7 stall stability", hold_err, 0);

        // R11: resume with a new current and tail pointer
        base = nexp;
        exp_desc(11);
        write_cur(dbase(11));
        check(cur_ptr_o == AW'(dbase(11)), "R11 pointer write while idle", cur_ptr_o, dbase(11));
        write_tail(dbase(11));
        check(idle_o == 1'b0, "R11 tail write clears idle", idle_o, 0);
        wait_stop();
        check(idle_o == 1'b1, "R11 resumed walk ends idle", idle_o, 1);
        cmp_log(base);
        check(mem[dbase(11) / 4 + 7] == 32'h8000_0007, "R8 status of resumed descriptor",
              mem[dbase(11) / 4 + 7], 32'h8000_0007);
        check(neof == 5, "R9 pulse for resumed frame", neof, 5);

        // R3: refetch of an already complete descriptor halts
        wr0 = nwr; act0 = nact; req0 = nreq;
        write_tail(dbase(11));
        wait_stop();
        check(halted_o == 1'b1, "R3 complete descriptor halts", halted_o, 1);
        check(nreq - req0 == 1, "R3 only the status word read", nreq - req0, 1);
        check(nwr == wr0, "R3 no write-back", nwr, wr0);
        check(nact == act0, "R3 no beats", nact, act0);
        check(cur_ptr_o == AW'(dbase(11)), "R3 pointer unchanged", cur_ptr_o, dbase(11));
        check(neof == 5, "R9 no pulse on halt", neof, 5);
        check(hold_err == 0, "R7 stall stability overall", hold_err, 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (WD_LIMIT) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        if (wd_hit) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule